// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the interlock and operand-bypass control for an in-order integer pipeline with five steps: fetch, decode, execute, memory and writeback. It comes with a small stage-register model and a register file, so it can run real dependence chains. The testbench, or a fetch unit, feeds it decoded instruction descriptors. Each descriptor carries two source register numbers with read flags, a destination number with a write enable, a load flag and an immediate. The controller holds fetch and decode and injects an empty slot into execute whenever a read-after-write dependence cannot be served yet. It also drives the two ALU operand multiplexers.

A static input picks the hazard policy. With bypassing off, a dependent instruction waits in decode until its producer reaches writeback. With bypassing on, only a load followed at once by a user of its result costs a cycle. Every other dependence is served from the stage registers after execute or after memory.

The descriptor input is a valid/ready stream. A descriptor counts as taken only on a cycle where both `in_valid` and `in_ready` are high. While `in_ready` is low the source must hold the same descriptor. A cycle with `in_valid` low sends an empty slot into decode. The retire port has no back-pressure: every instruction reaching writeback shows for exactly one cycle on `wb_valid`.

Top module: `hazard_bypass_pipe`

## Requirements
- R1: While reset is low and in the first cycle after it, `wb_valid` is 0, `in_ready` is 1 and both operand selects are 00. Register n holds the value n after reset, and register 0 always reads as 0.
- R2: Results are produced as follows. An ALU instruction computes src1 + (src2 if its second read flag is set, else the immediate). A load computes the bitwise inverse of src1 + immediate. An operand whose read flag is clear counts as zero. Instructions retire on `wb_rd`/`wb_data` in program order, one cycle each, whether or not they write a register.
- R3: With bypassing off, a consumer stays in decode while its producer is in execute or memory. This gives 2 stall cycles at distance 1, 1 at distance 2 and none from distance 3, and both operand selects stay 00.
- R4: With bypassing on, a dependence on an ALU result causes no stall. A load followed directly by a consumer of its destination costs exactly one stall cycle. A load separated from its consumer by one or more other instructions costs none.
- R5: In a stall cycle `stall_if`, `stall_id` and `bubble_ex` are all high and `in_ready` is low. Decode keeps its instruction in the following cycle, and execute holds an empty slot in that cycle.
- R6: A destination of register 0 never causes a stall or a bypass.
- R7: Only source operands whose read flag is set are checked, and only against producers whose write enable is set.
- R8: The operand select codes are 00 for the register-file value, 01 for the result held after execute, and 10 for the result held after memory. When both stages hold the matching destination, 01 (the younger result) wins.
- R9: A register written in writeback is seen by a read in decode in that same cycle.
- R10: The five-instruction test chain (load r4; r5=r4+10; r2=r2+r3; load r1 from r2; r1=r1+r5) takes 15 cycles without bypassing and 11 with it, counted from first fetch to last writeback. Moving the third instruction up to second place gives 12 and 10.
- R11: A descriptor is taken only when `in_valid` and `in_ready` are both high, and an idle input cycle adds exactly one cycle to the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_mode | input | 1 | 0: stall until writeback, 1: full bypass; change only in reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_rs1 | input | 4 | First source register |
| in_rs2 | input | 4 | Second source register |
| in_rd | input | 4 | Destination register |
| in_use1 | input | 1 | First source is read |
| in_use2 | input | 1 | Second source is read (else immediate) |
| in_wen | input | 1 | Destination is written |
| in_load | input | 1 | Instruction is a load |
| in_imm | input | 16 | Immediate |
| stall_if | output | 1 | Fetch held |
| stall_id | output | 1 | Decode held |
| bubble_ex | output | 1 | Empty slot sent into execute |
| fwd_sel_a | output | 2 | First ALU operand select |
| fwd_sel_b | output | 2 | Second ALU operand select |
| wb_valid | output | 1 | An instruction is in writeback |
| wb_rd | output | 4 | Its destination |
| wb_data | output | 16 | Its result |

## Verification
The embedded properties watch the policy on every cycle. They check that a stall freezes decode and empties execute, that no bypass is selected with bypassing off, that every stall under bypassing comes from a load in execute, that no bypass serves register 0, and that the post-execute path never carries an unfinished load. Exact stall counts per distance, the effect of read flags and write enables, select priority, same-cycle writeback reads and the total cycle counts of whole chains only show up in the bench's scenarios. There, retired values and cycle totals are compared with arithmetic expectations.

// File: rtl/hzp_pkg.sv
package hzp_pkg;
  localparam int XLEN  = 16;
  localparam int RBITS = 4;
  localparam int NREGS = 1 << RBITS;

  typedef enum logic [1:0] {
    FW_RF    = 2'b00,
    FW_EXMEM = 2'b01,
    FW_MEMWB = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic             valid;
    logic [RBITS-1:0] rs1;
    logic [RBITS-1:0] rs2;
    logic [RBITS-1:0] rd;
    logic             use1;
    logic             use2;
    logic             wen;
    logic             is_load;
    logic [XLEN-1:0]  imm;
  } instr_t;

  typedef struct packed {
    instr_t          ins;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
  } ex_slot_t;

  typedef struct packed {
    instr_t          ins;
    logic [XLEN-1:0] res;
  } res_slot_t;
endpackage

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int XLEN  = 16,
  parameter int NREGS = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= XLEN'(i);
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  // Read ports: zero register, then same-cycle writeback value, then storage.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)                  rdata[p] = '0;
      else if (we && waddr == raddr[p])    rdata[p] = wdata;
      else                                 rdata[p] = regs[raddr[p]];
    end
  end
endmodule

// File: rtl/hz_hazard.sv
module hz_hazard
  import hzp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fwd_mode,
  input  instr_t   id_ins,
  input  instr_t   ex_ins,
  input  instr_t   mem_ins,
  input  instr_t   wb_ins,
  output logic     stall,
  output fwd_sel_e sel_a,
  output fwd_sel_e sel_b
);
  localparam int NOPND = 2;

  function automatic logic writes_reg(instr_t p, logic [RBITS-1:0] r);
    return p.valid && p.wen && (p.rd != '0) && (p.rd == r);
  endfunction

  logic [NOPND-1:0][RBITS-1:0] id_src, ex_src;
  logic [NOPND-1:0]            id_rd, ex_rd, haz;
  fwd_sel_e                    sel [NOPND];

  assign id_src[0] = id_ins.rs1;
  assign id_src[1] = id_ins.rs2;
  assign id_rd[0]  = id_ins.valid && id_ins.use1;
  assign id_rd[1]  = id_ins.valid && id_ins.use2;
  assign ex_src[0] = ex_ins.rs1;
  assign ex_src[1] = ex_ins.rs2;
  assign ex_rd[0]  = ex_ins.valid && ex_ins.use1;
  assign ex_rd[1]  = ex_ins.valid && ex_ins.use2;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    // Decode-side interlock per operand.
    assign haz[k] = !id_rd[k] ? 1'b0 :
                    fwd_mode  ? (ex_ins.is_load && writes_reg(ex_ins, id_src[k])) :
                                (writes_reg(ex_ins, id_src[k]) || writes_reg(mem_ins, id_src[k]));
    // Execute-side bypass select, younger stage first.
    assign sel[k] = (!fwd_mode || !ex_rd[k])      ? FW_RF    :
                    writes_reg(mem_ins, ex_src[k]) ? FW_EXMEM :
                    writes_reg(wb_ins, ex_src[k])  ? FW_MEMWB : FW_RF;
  end

  assign stall = |haz;
  assign sel_a = sel[0];
  assign sel_b = sel[1];

  // R4
  fwd_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode && stall) |-> (ex_ins.valid && ex_ins.is_load));
endmodule

// File: rtl/hz_exec.sv
module hz_exec
  import hzp_pkg::*;
(
  input  instr_t          ins,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] exmem_val,
  input  logic [XLEN-1:0] memwb_val,
  input  fwd_sel_e        sel_a,
  input  fwd_sel_e        sel_b,
  output logic [XLEN-1:0] result
);
  function automatic logic [XLEN-1:0] pick(fwd_sel_e s, logic [XLEN-1:0] rf,
                                           logic [XLEN-1:0] em, logic [XLEN-1:0] mw);
    case (s)
      FW_EXMEM: return em;
      FW_MEMWB: return mw;
      default:  return rf;
    endcase
  endfunction

  logic [XLEN-1:0] opa, opb;

  always_comb begin
    opa    = ins.use1 ? pick(sel_a, rf_a, exmem_val, memwb_val) : '0;
    opb    = ins.use2 ? pick(sel_b, rf_b, exmem_val, memwb_val) : ins.imm;
    result = opa + opb;
  end
endmodule

// File: rtl/hazard_bypass_pipe.sv
module hazard_bypass_pipe
  import hzp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RBITS-1:0] in_rs1,
  input  logic [RBITS-1:0] in_rs2,
  input  logic [RBITS-1:0] in_rd,
  input  logic             in_use1,
  input  logic             in_use2,
  input  logic             in_wen,
  input  logic             in_load,
  input  logic [XLEN-1:0]  in_imm,
  output logic             stall_if,
  output logic             stall_id,
  output logic             bubble_ex,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             wb_valid,
  output logic [RBITS-1:0] wb_rd,
  output logic [XLEN-1:0]  wb_data
);
  instr_t    in_ins, id_q;
  ex_slot_t  ex_q;
  res_slot_t mem_q, wb_q;

  logic                      stall;
  fwd_sel_e                  sel_a, sel_b;
  logic [1:0][RBITS-1:0]     rf_addr;
  logic [1:0][XLEN-1:0]      rf_data;
  logic [XLEN-1:0]           ex_res, mem_out;

  always_comb begin
    in_ins.valid   = in_valid;
    in_ins.rs1     = in_rs1;
    in_ins.rs2     = in_rs2;
    in_ins.rd      = in_rd;
    in_ins.use1    = in_use1;
    in_ins.use2    = in_use2;
    in_ins.wen     = in_wen;
    in_ins.is_load = in_load;
    in_ins.imm     = in_imm;
  end

  assign rf_addr[0] = id_q.rs1;
  assign rf_addr[1] = id_q.rs2;

  hz_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_q.ins.valid && wb_q.ins.wen),
    .waddr (wb_q.ins.rd),
    .wdata (wb_q.res),
    .raddr (rf_addr),
    .rdata (rf_data)
  );

  hz_hazard u_hz (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_mode (fwd_mode),
    .id_ins   (id_q),
    .ex_ins   (ex_q.ins),
    .mem_ins  (mem_q.ins),
    .wb_ins   (wb_q.ins),
    .stall    (stall),
    .sel_a    (sel_a),
    .sel_b    (sel_b)
  );

  hz_exec u_ex (
    .ins       (ex_q.ins),
    .rf_a      (ex_q.a),
    .rf_b      (ex_q.b),
    .exmem_val (mem_q.res),
    .memwb_val (wb_q.res),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .result    (ex_res)
  );

  // Memory stage: a load returns the inverse of its effective address.
  assign mem_out = mem_q.ins.is_load ? ~mem_q.res : mem_q.res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      wb_q.ins  <= mem_q.ins;
      wb_q.res  <= mem_out;
      mem_q.ins <= ex_q.ins;
      mem_q.res <= ex_res;
      if (stall) begin
        ex_q <= '0;
      end else begin
        ex_q.ins <= id_q;
        ex_q.a   <= rf_data[0];
        ex_q.b   <= rf_data[1];
        id_q     <= in_ins;
      end
    end
  end

  assign in_ready  = !stall;
  assign stall_if  = stall;
  assign stall_id  = stall;
  assign bubble_ex = stall;
  assign fwd_sel_a = sel_a;
  assign fwd_sel_b = sel_b;
  assign wb_valid  = wb_q.ins.valid;
  assign wb_rd     = wb_q.ins.rd;
  assign wb_data   = wb_q.res;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(id_q));
  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_q.ins.valid);
  // R3
  nofwd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_mode |-> (sel_a == FW_RF && sel_b == FW_RF));
  // R8
  exmem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == FW_EXMEM || sel_b == FW_EXMEM) |-> !mem_q.ins.is_load);
  // R6
  zero_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_a != FW_RF) |-> (ex_q.ins.rs1 != '0)) and ((sel_b != FW_RF) |-> (ex_q.ins.rs2 != '0)));
endmodule

// File: tb/hazard_bypass_pipe_test.sv
module hazard_bypass_pipe_test;
  import hzp_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             rst_n, fwd_mode, in_valid, in_ready;
  logic [RBITS-1:0] in_rs1, in_rs2, in_rd, wb_rd;
  logic             in_use1, in_use2, in_wen, in_load;
  logic [XLEN-1:0]  in_imm, wb_data;
  logic             stall_if, stall_id, bubble_ex, wb_valid;
  logic [1:0]       fwd_sel_a, fwd_sel_b;

  hazard_bypass_pipe uut (
    .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
    .in_use1(in_use1), .in_use2(in_use2), .in_wen(in_wen), .in_load(in_load),
    .in_imm(in_imm),
    .stall_if(stall_if), .stall_id(stall_id), .bubble_ex(bubble_ex),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  int checks = 0;
  int errors = 0;
  instr_t prog [8];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic instr_t mk(int rs1, int rs2, int rd, bit u1, bit u2,
                                bit we, bit ld, int imm);
    instr_t x;
    x.valid = 1'b1; x.rs1 = RBITS'(rs1); x.rs2 = RBITS'(rs2); x.rd = RBITS'(rd);
    x.use1 = u1; x.use2 = u2; x.wen = we; x.is_load = ld; x.imm = XLEN'(imm);
    return x;
  endfunction

  task automatic drive(input instr_t x, input bit v);
    in_valid = v; in_rs1 = x.rs1; in_rs2 = x.rs2; in_rd = x.rd;
    in_use1 = x.use1; in_use2 = x.use2; in_wen = x.wen; in_load = x.is_load;
    in_imm = x.imm;
  endtask

  task automatic do_reset(input bit mode);
    drive('0, 1'b0);
    rst_n = 1'b0;
    fwd_mode = mode;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Runs prog[0..n-1]; checks retired values, cycle total and bypass selects.
  task automatic run_prog(input int n, input bit mode, input int exp_cyc,
                          input string ctag, input int gap, input int opnd,
                          input int exp_mask);
    logic [XLEN-1:0] rm [NREGS];
    logic [XLEN-1:0] ev [8];
    int idx = 0, ret = 0, cyc = 0, first = 0, last = -1;
    int stall_seen = 0, stall_bad = 0, gap_done = 0;
    int mask [2];
    mask[0] = 0; mask[1] = 0;
    for (int r = 0; r < NREGS; r++) rm[r] = XLEN'(r);
    for (int k = 0; k < n; k++) begin
      logic [XLEN-1:0] a, b, s;
      a = !prog[k].use1 ? '0 : (prog[k].rs1 == 0 ? '0 : rm[prog[k].rs1]);
      b = !prog[k].use2 ? prog[k].imm : (prog[k].rs2 == 0 ? '0 : rm[prog[k].rs2]);
      s = a + b;
      ev[k] = prog[k].is_load ? ~s : s;
      if (prog[k].wen && prog[k].rd != 0) rm[prog[k].rd] = ev[k];
    end
    do_reset(mode);
    while (ret < n && cyc < 100) begin
      @(negedge clk);
      if (wb_valid) begin
        // R2 R9: value and order of retirement
        check(wb_rd == prog[ret].rd && wb_data == ev[ret], "R2 R9",
              $sformatf("%s retire %0d data", ctag, ret), int'(wb_data), int'(ev[ret]));
        ret++;
        last = cyc;
      end
      if (stall_id) begin
        stall_seen++;
        if (in_ready || !stall_if || !bubble_ex) stall_bad++;
      end
      if (fwd_sel_a == 2'b01) mask[0] |= 1;
      if (fwd_sel_a == 2'b10) mask[0] |= 2;
      if (fwd_sel_b == 2'b01) mask[1] |= 1;
      if (fwd_sel_b == 2'b10) mask[1] |= 2;
      if (idx < n && !(idx == gap && gap_done == 0)) begin
        drive(prog[idx], 1'b1);
        if (in_ready) begin
          if (idx == 0) first = cyc;
          idx++;
        end
      end else begin
        drive('0, 1'b0);
        if (idx == gap) gap_done = 1;
      end
      cyc++;
    end
    drive('0, 1'b0);
    check(ret == n, "R2", {ctag, " retire count"}, ret, n);
    check(last - first + 1 == exp_cyc, ctag, "cycle total", last - first + 1, exp_cyc);
    if (stall_seen > 0)
      check(stall_bad == 0, "R5", {ctag, " stall signals"}, stall_bad, 0);
    if (opnd >= 0) begin
      check(mask[opnd] == exp_mask, "R8", {ctag, " select seen"}, mask[opnd], exp_mask);
      check(mask[1 - opnd] == 0, "R8", {ctag, " other select"}, mask[1 - opnd], 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    fwd_mode = 1'b1;
    drive('0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!wb_valid && in_ready && fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00,
          "R1", "reset outputs", {wb_valid, in_ready, fwd_sel_a, fwd_sel_b}, 6'b010000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wb_valid && in_ready, "R1", "after reset", {wb_valid, in_ready}, 2'b01);

    // R3 R4 R8: producer/consumer distance sweep, both modes, both operands
    for (int m = 0; m < 2; m++)
      for (int ld = 0; ld < 2; ld++)
        for (int d = 1; d <= 4; d++)
          for (int op = 0; op < 2; op++) begin
            int st, em;
            prog[0] = mk(1, 0, 5, 1, 0, 1, ld[0], 7);
            for (int f = 1; f < d; f++) prog[f] = mk(2, 0, 7 + f, 1, 0, 1, 0, f);
            prog[d] = (op == 0) ? mk(5, 3, 6, 1, 1, 1, 0, 0) : mk(3, 5, 6, 1, 1, 1, 0, 0);
            if (m == 0) st = (d < 3) ? 3 - d : 0;
            else        st = (ld == 1 && d == 1) ? 1 : 0;
            if (m == 0)      em = 0;
            else if (d == 1) em = (ld == 1) ? 2 : 1;
            else if (d == 2) em = 2;
            else             em = 0;
            run_prog(d + 1, m[0], d + 5 + st, (m == 0) ? "R3" : "R4", -1, op, em);
          end

    for (int m = 0; m < 2; m++) begin
      // R6: load into register 0 followed by a reader of register 0
      prog[0] = mk(1, 0, 0, 1, 0, 1, 1, 7);
      prog[1] = mk(0, 3, 6, 1, 1, 1, 0, 0);
      run_prog(2, m[0], 6, "R6", -1, 0, 0);
      // R7: producer without write enable
      prog[0] = mk(1, 0, 5, 1, 0, 0, 1, 7);
      prog[1] = mk(5, 3, 6, 1, 1, 1, 0, 0);
      run_prog(2, m[0], 6, "R7", -1, 0, 0);
      // R7: matching field on an operand that is not read
      prog[0] = mk(1, 0, 5, 1, 0, 1, 1, 7);
      prog[1] = mk(3, 5, 6, 1, 0, 1, 0, 4);
      run_prog(2, m[0], 6, "R7", -1, 1, 0);
      // R8: two producers of the same register, younger one wins
      prog[0] = mk(1, 0, 5, 1, 0, 1, 0, 10);
      prog[1] = mk(2, 0, 5, 1, 0, 1, 0, 20);
      prog[2] = mk(5, 3, 6, 1, 1, 1, 0, 0);
      run_prog(3, m[0], (m == 0) ? 9 : 7, "R8", -1, 0, (m == 0) ? 0 : 1);
    end

    // R10: the five-instruction chain, original and reordered
    prog[0] = mk(1, 0, 4, 1, 0, 1, 1, 0);
    prog[1] = mk(4, 0, 5, 1, 0, 1, 0, 10);
    prog[2] = mk(2, 3, 2, 1, 1, 1, 0, 0);
    prog[3] = mk(2, 0, 1, 1, 0, 1, 1, 20);
    prog[4] = mk(1, 5, 1, 1, 1, 1, 0, 0);
    run_prog(5, 1'b0, 15, "R10", -1, -1, 0);
    run_prog(5, 1'b1, 11, "R10", -1, -1, 0);
    prog[1] = mk(2, 3, 2, 1, 1, 1, 0, 0);
    prog[2] = mk(4, 0, 5, 1, 0, 1, 0, 10);
    run_prog(5, 1'b0, 12, "R10", -1, -1, 0);
    run_prog(5, 1'b1, 10, "R10", -1, -1, 0);

    // R11: one idle input cycle between independent instructions
    prog[0] = mk(1, 0, 8, 1, 0, 1, 0, 1);
    prog[1] = mk(2, 0, 9, 1, 0, 1, 0, 2);
    prog[2] = mk(3, 0, 10, 1, 0, 1, 0, 3);
    run_prog(3, 1'b1, 8, "R11", 1, -1, 0);
    run_prog(3, 1'b0, 8, "R11", 1, -1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule